// File: doc/BRIEF.md
# Signed Non-Restoring Fixed-Point Divider

This block divides an N-bit dividend by an N-bit divisor and returns a 2N-bit fixed-point quotient with N integer bits above the binary point and N fractional bits below it, together with an N-bit remainder. It works one quotient digit per clock. Each step doubles the partial remainder, shifts in the next dividend bit, and then adds or subtracts the divisor. In two's complement mode the digits are drawn from {-1,+1} and stored as single bits. A final cycle turns them into an ordinary two's complement quotient and corrects the remainder once if it needs it, so negative operands never need to be converted to magnitudes first.

A mode input selects unsigned operands, and a second input replaces the dividend with the value one to form a reciprocal. A requester drives the operands and pulses `start` while the block is idle. The block latches everything at that edge, raises `busy`, and later pulses `done` for one cycle with the results. Those results stay on the outputs until the next operation completes. A zero divisor skips the iterations, raises a flag and returns zeros.

Top module: `sd_fixdiv`

## Requirements
- R1: After reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: `start` is accepted only while `busy` is low. A `start` pulse during an operation is ignored: it neither changes the result in progress nor begins a second operation.
- R3: For a nonzero divisor, `done` is high for exactly one cycle, beginning 2N+1 clock edges after the accepting edge. `busy` is high from the accepting edge until that `done`.
- R4: In signed mode (`is_unsigned`=0), `quotient` is A·2^N / D truncated toward zero, as a 2N-bit two's complement value. Bits [2N-1:N] hold the integer part and bits [N-1:0] the fraction. The one out-of-range case, A=-2^(N-1) with D=-1, wraps to 2N bits (0x8000 for N=8).
- R5: In signed mode, `remainder` = A·2^N − quotient·D, with |remainder| < |D|. It is either zero or carries the sign of the dividend, and is given as N-bit two's complement.
- R6: In unsigned mode (`is_unsigned`=1), both operands are plain binary, `quotient` = floor(A·2^N / D), and `remainder` = A·2^N − quotient·D < D.
- R7: With `recip`=1, the `dividend` input is ignored and the dividend is taken as +1 in either mode, so the quotient is 2^N / D.
- R8: A divisor of all zeros sets `div_by_zero` and gives zero `quotient` and `remainder`. `done` pulses right after the accepting edge. The flag clears when the next operation with a nonzero divisor completes.
- R9: `quotient`, `remainder` and `div_by_zero` change only on the edge that raises `done`. They hold between completions, including while a new operation runs.
- R10: Operand and mode inputs are sampled only on the accepting edge. Changing them while `busy` is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only when idle |
| is_unsigned | input | 1 | 1: unsigned operands, 0: two's complement |
| recip | input | 1 | 1: dividend forced to one (reciprocal) |
| dividend | input | DW | Dividend A |
| divisor | input | DW | Divisor D |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 2*DW | Fixed-point quotient, DW fraction bits |
| remainder | output | DW | Remainder of A·2^DW / D |
| div_by_zero | output | 1 | Last operation had a zero divisor |

## Verification
The completion-pulse property assumes that `start` is low in the cycle `done` is seen, except where a zero-divisor request follows directly. The stimulus therefore always leaves at least one idle cycle after each completion. The remainder-sign and remainder-bound properties are evaluated against the mode, divisor and dividend sign latched at acceptance, not against the live inputs. For this reason the bench scrambles the operand and mode inputs as soon as `start` is taken, and fires a stray `start` mid-run. Divisor zero, the most negative dividend and the signed overflow case are driven as directed cases, because random operands rarely reach them.

// File: rtl/sd_fixdiv_pkg.sv
package sd_fixdiv_pkg;

  // controller phases: waiting, digit iterations, final conversion
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } dstate_e;

endpackage

// File: rtl/sd_fixdiv_ctrl.sv
module sd_fixdiv_ctrl
  import sd_fixdiv_pkg::*;
#(
  parameter int QW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dz,
  output logic accept,
  output logic step_en,
  output logic finish,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(QW);
  localparam logic [CW-1:0] LAST = CW'(QW - 1);

  dstate_e        state;
  logic [CW-1:0]  cnt;

  always_comb begin
    accept  = start && (state == ST_IDLE);
    step_en = (state == ST_RUN);
    finish  = (state == ST_FIX);
    busy    = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (dz) begin
              done <= 1'b1;
            end else begin
              state <= ST_RUN;
              cnt   <= '0;
            end
          end
        end
        ST_RUN: begin
          cnt <= cnt + CW'(1);
          if (cnt == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sd_fixdiv_step.sv
module sd_fixdiv_step #(
  parameter int RW = 10
) (
  input  logic [RW-1:0] rem_i,
  input  logic [RW-1:0] dvs_i,
  input  logic          xin_i,
  input  logic          uns_i,
  output logic [RW-1:0] rem_o,
  output logic          dig_o
);

  // one radix-2 step; returns {digit, next partial remainder}
  function automatic logic [RW:0] nr_step(input logic [RW-1:0] r,
                                          input logic [RW-1:0] d,
                                          input logic x,
                                          input logic u);
    logic [RW-1:0] sh;
    logic [RW-1:0] t;
    logic          q;
    sh = {r[RW-2:0], x};
    if (u) begin
      // plain binary digit: decided from the sign of the new remainder
      if (!r[RW-1]) t = sh - d;
      else          t = sh + d;
      q = ~t[RW-1];
    end else begin
      // signed digit: +1 when signs agree (subtract), -1 otherwise (add)
      if (r[RW-1] == d[RW-1]) begin
        t = sh - d;
        q = 1'b1;
      end else begin
        t = sh + d;
        q = 1'b0;
      end
    end
    return {q, t};
  endfunction

  logic [RW:0] res;

  always_comb begin
    res   = nr_step(rem_i, dvs_i, xin_i, uns_i);
    dig_o = res[RW];
    rem_o = res[RW-1:0];
  end

endmodule

// File: rtl/sd_fixdiv_fix.sv
module sd_fixdiv_fix #(
  parameter int DW = 8,
  parameter int QW = 16,
  parameter int RW = 10
) (
  input  logic [RW-1:0] rem_i,
  input  logic [QW-1:0] dig_i,
  input  logic [RW-1:0] dvs_i,
  input  logic          uns_i,
  input  logic          xneg_i,
  output logic [QW-1:0] q_o,
  output logic [DW-1:0] r_o
);

  localparam int XW = QW + 2;

  // digits d_i in {-1,+1} stored as b_i: value = 2B + 1 - 2^QW
  function automatic logic [XW-1:0] sd_to_tc(input logic [QW-1:0] b);
    return {1'b0, b, 1'b1} - (XW'(1) << QW);
  endfunction

  logic [XW-1:0] qsd;
  logic [XW-1:0] q_full;
  logic [RW-1:0] r_full;
  logic [RW-1:0] neg_abs_d;
  logic          r_neg;
  logic          r_nz;
  logic          wrong_sign;
  logic          at_bound;
  logic          need_fix;

  always_comb begin
    qsd        = sd_to_tc(dig_i);
    r_neg      = rem_i[RW-1];
    r_nz       = |rem_i;
    neg_abs_d  = dvs_i[RW-1] ? dvs_i : (~dvs_i + RW'(1));
    wrong_sign = r_nz && (r_neg != xneg_i);
    at_bound   = (rem_i == neg_abs_d);
    need_fix   = wrong_sign || at_bound;

    if (uns_i) begin
      q_full = {2'b00, dig_i};
      r_full = r_neg ? (rem_i + dvs_i) : rem_i;
    end else if (need_fix && (r_neg == dvs_i[RW-1])) begin
      q_full = qsd + XW'(1);
      r_full = rem_i - dvs_i;
    end else if (need_fix) begin
      q_full = qsd - XW'(1);
      r_full = rem_i + dvs_i;
    end else begin
      q_full = qsd;
      r_full = rem_i;
    end

    q_o = q_full[QW-1:0];
    r_o = r_full[DW-1:0];
  end

endmodule

// File: rtl/sd_fixdiv.sv
module sd_fixdiv #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_unsigned,
  input  logic              recip,
  input  logic [DW-1:0]     dividend,
  input  logic [DW-1:0]     divisor,
  output logic              busy,
  output logic              done,
  output logic [2*DW-1:0]   quotient,
  output logic [DW-1:0]     remainder,
  output logic              div_by_zero
);

  localparam int QW = 2 * DW;
  localparam int RW = DW + 2;

  // control events
  logic accept;
  logic step_en;
  logic finish;
  logic dz_in;

  // latched operation
  logic          op_uns;
  logic          op_xneg;
  logic [RW-1:0] op_dvs;
  logic [RW-1:0] part_rem;
  logic [QW-1:0] xq_sh;     // dividend bits leave at the top, digits enter at the bottom

  // datapath results
  logic [DW-1:0] opnd;
  logic [RW-1:0] rem_nx;
  logic          step_dig;
  logic [QW-1:0] fix_q;
  logic [DW-1:0] fix_r;

  // result registers
  logic [QW-1:0] q_r;
  logic [DW-1:0] r_r;
  logic          z_r;

  always_comb begin
    dz_in = (divisor == '0);
    opnd  = recip ? DW'(1) : dividend;
  end

  sd_fixdiv_ctrl #(.QW(QW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .dz      (dz_in),
    .accept  (accept),
    .step_en (step_en),
    .finish  (finish),
    .busy    (busy),
    .done    (done)
  );

  sd_fixdiv_step #(.RW(RW)) u_step (
    .rem_i (part_rem),
    .dvs_i (op_dvs),
    .xin_i (xq_sh[QW-1]),
    .uns_i (op_uns),
    .rem_o (rem_nx),
    .dig_o (step_dig)
  );

  sd_fixdiv_fix #(.DW(DW), .QW(QW), .RW(RW)) u_fix (
    .rem_i  (part_rem),
    .dig_i  (xq_sh),
    .dvs_i  (op_dvs),
    .uns_i  (op_uns),
    .xneg_i (op_xneg),
    .q_o    (fix_q),
    .r_o    (fix_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_uns   <= 1'b0;
      op_xneg  <= 1'b0;
      op_dvs   <= '0;
      part_rem <= '0;
      xq_sh    <= '0;
    end else if (accept) begin
      op_uns   <= is_unsigned;
      op_xneg  <= !is_unsigned && opnd[DW-1];
      op_dvs   <= is_unsigned ? {2'b00, divisor} : {{2{divisor[DW-1]}}, divisor};
      part_rem <= (!is_unsigned && opnd[DW-1]) ? '1 : '0;
      xq_sh    <= {opnd, {DW{1'b0}}};
    end else if (step_en) begin
      part_rem <= rem_nx;
      xq_sh    <= {xq_sh[QW-2:0], step_dig};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
      r_r <= '0;
      z_r <= 1'b0;
    end else if (accept && dz_in) begin
      q_r <= '0;
      r_r <= '0;
      z_r <= 1'b1;
    end else if (finish) begin
      q_r <= fix_q;
      r_r <= fix_r;
      z_r <= 1'b0;
    end
  end

  always_comb begin
    quotient    = q_r;
    remainder   = r_r;
    div_by_zero = z_r;
  end

endmodule

// File: rtl/sd_fixdiv_chk.sv
module sd_fixdiv_chk #(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              accept,
  input logic              busy,
  input logic              done,
  input logic [2*DW-1:0]   quotient,
  input logic [DW-1:0]     remainder,
  input logic              div_by_zero,
  input logic              op_uns,
  input logic              op_xneg,
  input logic [DW+1:0]     op_dvs
);

  localparam logic [7:0] RUN_LAT = 8'(2 * DW + 2);

  logic [7:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              lat_cnt <= '0;
    else if (accept)                         lat_cnt <= 8'd1;
    else if (lat_cnt != 0 && lat_cnt != '1)  lat_cnt <= lat_cnt + 8'd1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);  // R3

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((lat_cnt == RUN_LAT) || (div_by_zero && lat_cnt == 8'd1)));  // R3

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));  // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));  // R9

  AST_ZERO_DIV_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> (quotient == '0 && remainder == '0));  // R8

  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero && !op_uns && remainder != '0) |-> (remainder[DW-1] == op_xneg));  // R5

  AST_REM_BOUND_UNS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero && op_uns) |-> (remainder < op_dvs[DW-1:0]));  // R6

endmodule

bind sd_fixdiv sd_fixdiv_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .accept      (accept),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero),
  .op_uns      (op_uns),
  .op_xneg     (op_xneg),
  .op_dvs      (op_dvs)
);

// File: tb/test_sd_fixdiv.sv
module test_sd_fixdiv;

  localparam int DW = 8;
  localparam int QW = 2 * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          is_unsigned = 1'b0;
  logic          recip = 1'b0;
  logic [DW-1:0] dividend = '0;
  logic [DW-1:0] divisor = '0;
  logic          busy;
  logic          done;
  logic [QW-1:0] quotient;
  logic [DW-1:0] remainder;
  logic          div_by_zero;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  sd_fixdiv #(.DW(DW)) i_sd_fixdiv (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .is_unsigned (is_unsigned),
    .recip       (recip),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference: widened integer division, truncating toward zero
  function automatic void ref_div(input logic [DW-1:0] a, input logic [DW-1:0] d,
                                  input bit uns, input bit rcp,
                                  output logic [QW-1:0] q, output logic [DW-1:0] r,
                                  output bit z);
    logic [DW-1:0] aa;
    longint xa, xd, xq, xr;
    aa = rcp ? DW'(1) : a;
    if (d == '0) begin
      q = '0; r = '0; z = 1'b1;
      return;
    end
    if (uns) begin
      xa = longint'(aa);
      xd = longint'(d);
    end else begin
      xa = longint'($signed(aa));
      xd = longint'($signed(d));
    end
    xa = xa * (longint'(1) << DW);
    xq = xa / xd;
    xr = xa % xd;
    q = xq[QW-1:0];
    r = xr[DW-1:0];
    z = 1'b0;
  endfunction

  task automatic run_op(input logic [DW-1:0] a, input logic [DW-1:0] d,
                        input bit uns, input bit rcp, input bit poke);
    logic [QW-1:0] eq, hq;
    logic [DW-1:0] er, hr;
    bit            ez, hz, steady;
    int            cyc;
    string         tq, tr;
    ref_div(a, d, uns, rcp, eq, er, ez);
    tq = uns ? "R6" : (rcp ? "R7" : "R4");
    tr = uns ? "R6" : (rcp ? "R7" : "R5");
    @(negedge clk);
    dividend = a; divisor = d; is_unsigned = uns; recip = rcp; start = 1'b1;
    hq = quotient; hr = remainder; hz = div_by_zero; steady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: inputs change right after acceptance
    dividend = DW'($urandom); divisor = DW'($urandom);
    is_unsigned = 1'($urandom); recip = 1'($urandom);
    cyc = 1;
    while (!done && cyc < 100) begin
      if (quotient != hq || remainder != hr || div_by_zero != hz) steady = 1'b0;
      if (!busy) steady = 1'b0;
      start = (poke && cyc == 3);  // R2: stray request while busy
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == (ez ? 1 : QW + 2), "R3", "done latency", cyc, ez ? 1 : QW + 2);
    check(quotient == eq, {tq, " R10"}, "quotient", quotient, eq);
    check(remainder == er, {tr, " R10"}, "remainder", remainder, er);
    check(div_by_zero == ez, "R8", "div_by_zero", div_by_zero, ez);
    check(steady, "R9", "results held while busy", steady, 1);
    @(negedge clk);
    check(!done && !busy, "R2", "single pulse, no second run", {done, busy}, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values
    check(!busy && !done && !div_by_zero, "R1", "status after reset",
          {busy, done, div_by_zero}, 0);
    check(quotient == '0 && remainder == '0, "R1", "results after reset",
          {quotient, remainder}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed signed cases (R4, R5)
    run_op(8'd7,   8'd2,   0, 0, 0);
    run_op(8'hF9,  8'd2,   0, 0, 1);
    run_op(8'd7,   8'hFE,  0, 0, 0);
    run_op(8'hF9,  8'hFE,  0, 0, 1);
    run_op(8'h80,  8'hFF,  0, 0, 0);   // overflow wraps to 0x8000
    run_op(8'h80,  8'h80,  0, 0, 0);
    run_op(8'h7F,  8'h80,  0, 0, 0);
    run_op(8'hFD,  8'd3,   0, 0, 0);
    // reciprocal (R7)
    run_op(8'h55,  8'd3,   0, 1, 0);
    run_op(8'h00,  8'hFF,  0, 1, 0);
    run_op(8'h12,  8'h80,  0, 1, 0);
    run_op(8'hAA,  8'd7,   1, 1, 0);
    // unsigned (R6)
    run_op(8'hFF,  8'd1,   1, 0, 0);
    run_op(8'hFF,  8'hFF,  1, 0, 1);
    run_op(8'd1,   8'hFF,  1, 0, 0);
    // divide by zero and recovery (R8)
    run_op(8'd9,   8'd0,   0, 0, 0);
    run_op(8'd9,   8'd0,   1, 1, 0);
    run_op(8'd9,   8'd4,   0, 0, 0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [DW-1:0] ra, rd;
      ra = DW'($urandom);
      rd = ($urandom_range(0, 19) == 0) ? '0 : DW'($urandom);
      run_op(ra, rd, 1'($urandom), ($urandom_range(0, 7) == 0), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule